// File: doc/BRIEF.md
# Rename Map with Small-Immediate Folding

This block is the register-rename map of a small out-of-order integer core. Each architectural register maps to a physical register tag. The mapping can also carry a signed 11-bit offset, so an entry stands for "base tag plus a pending constant". A 64-bit move-immediate, add-immediate, subtract-immediate or increment whose result fits that offset range is absorbed at rename. Only the map entry changes, and the micro-op takes no execution slot. Every other register write gets a fresh physical tag and a plain mapping.

Up to `LANES` micro-ops (two by default) are renamed per cycle, in program order. A later lane sees the map updates made by earlier lanes in the same group. Each source operand is presented to downstream logic as a base tag, an offset and an offset-valid flag. The count operand of a shift is also flagged as slow when its value is folded, and the block reports the resulting latency class. All outputs are combinational from the current map and the inputs. The map and the allocation pointer update on the rising clock edge.

Top module: `rnm_imm_rename`

## Requirements
- R1: After reset, architectural register r maps to tag r+1 with the offset invalid and zero. Tag 0 is the always-zero register. The first allocated tag is 17 (with 16 architectural and 64 physical registers).
- R2: A 64-bit move-immediate (kind 2, width code 2) with an immediate in [-1024, 1023] folds. It does not issue, gets no tag and has latency 0, and the destination becomes tag 0 plus the immediate with the offset valid. An immediate of 1024 or of -1025 or below issues normally.
- R3: Writes of width code 0 (8-bit) or 1 (32-bit) never fold, for any kind. They allocate a new tag and leave a plain mapping.
- R4: A load (kind 6) always issues and leaves a plain mapping with the offset cleared, even when the destination held a folded value.
- R5: A 64-bit add-immediate (kind 3), subtract-immediate (kind 4) or increment (kind 5) keeps the source's base tag and sets offset = source offset ± immediate (+1 for increment), as long as the result stays in [-1024, 1023]. Outside that range it issues, allocates a tag and leaves a plain mapping.
- R6: Each source operand A and B is output as base tag, offset and offset-valid. A plain mapping shows offset 0.
- R7: The slow flag is set only on operand B of a shift (kind 1) whose mapping is folded. Latency is 3 for such a shift, 0 for a folded micro-op and 1 otherwise. A folded operand of a generic ALU op (kind 0) or on shift operand A adds no penalty.
- R8: Lanes are renamed in order. A later lane reads an earlier lane's destination update in the same cycle. When two lanes write the same register, the later lane's mapping is kept.
- R9: Issuing micro-ops take consecutive tags in lane order. Folded micro-ops take none. After tag 63 the next tag is 17.
- R10: A flush restores the identity mapping of R1 and restarts allocation at tag 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_flush | input | 1 | Restore identity map and allocation pointer |
| i_vld | input | LANES | Micro-op present in lane |
| i_kind | input | 3*LANES | 0 ALU, 1 shift (B is count), 2 move-imm, 3 add-imm, 4 sub-imm, 5 increment, 6 load |
| i_width | input | 2*LANES | 0 = 8-bit, 1 = 32-bit, 2 = 64-bit |
| i_dst | input | 4*LANES | Destination architectural register |
| i_srca | input | 4*LANES | Source A architectural register |
| i_srcb | input | 4*LANES | Source B architectural register |
| i_imm | input | 32*LANES | Signed immediate |
| o_a_tag | output | 6*LANES | Operand A base tag |
| o_a_ofs | output | 11*LANES | Operand A pending offset |
| o_a_ovld | output | LANES | Operand A offset valid |
| o_b_tag | output | 6*LANES | Operand B base tag |
| o_b_ofs | output | 11*LANES | Operand B pending offset |
| o_b_ovld | output | LANES | Operand B offset valid |
| o_b_slow | output | LANES | Operand B is a folded shift count |
| o_folded | output | LANES | Micro-op absorbed at rename |
| o_issue | output | LANES | Micro-op needs an execution slot |
| o_dst_tag | output | 6*LANES | Allocated destination tag (0 if none) |
| o_lat | output | 2*LANES | Latency class: 0, 1 or 3 |

## Verification
Some properties hold on every cycle, and the assertions check those. The slow flag appears only on a folded shift count, and such a shift always reports latency 3. Only 64-bit writes fold, loads always issue, plain mappings carry offset zero, issued micro-ops get a tag at or above the first free one, and the cycle after a flush shows the identity mapping. Other behaviour depends on history, and only the bench's scenarios can show it. This covers offset accumulation across several instructions, abandoning a fold at exactly 1023+1 and at -1025, a load clearing a folded register, same-cycle visibility between lanes, the later lane winning a shared destination, and the allocation pointer wrapping from 63 back to 17.

// File: rtl/rnm_pkg.sv
package rnm_pkg;
  localparam int ARCH_N = 16;
  localparam int PHYS_N = 64;
  localparam int OFS_W  = 11;
  localparam int IMM_W  = 32;
  localparam int KIND_W = 3;
  localparam int WID_W  = 2;
  localparam int AREG_W = $clog2(ARCH_N);
  localparam int TAG_W  = $clog2(PHYS_N);
  localparam int SUM_W  = IMM_W + 2;
  localparam int OFS_MAX = (2 ** (OFS_W - 1)) - 1;
  localparam int OFS_MIN = -(2 ** (OFS_W - 1));
  localparam logic [TAG_W-1:0] ZERO_TAG   = '0;
  localparam logic [TAG_W-1:0] FIRST_FREE = TAG_W'(ARCH_N + 1);
  localparam logic [TAG_W-1:0] LAST_TAG   = TAG_W'(PHYS_N - 1);

  typedef enum logic [KIND_W-1:0] {
    K_ALU = 3'd0, K_SHIFT = 3'd1, K_MOVI = 3'd2, K_ADDI = 3'd3,
    K_SUBI = 3'd4, K_INC = 3'd5, K_LOAD = 3'd6
  } kind_e;

  typedef enum logic [WID_W-1:0] {
    W8 = 2'd0, W32 = 2'd1, W64 = 2'd2
  } width_e;

  typedef struct packed {
    logic [TAG_W-1:0]        base;
    logic signed [OFS_W-1:0] ofs;
    logic                    fold;
  } map_ent_t;

  typedef struct packed {
    map_ent_t ent;
    logic     fold;
  } fold_res_t;

  function automatic map_ent_t ident_ent(input int a);
    map_ent_t e;
    e.base = TAG_W'(a + 1);
    e.ofs  = '0;
    e.fold = 1'b0;
    return e;
  endfunction

  function automatic logic [TAG_W-1:0] tag_next(input logic [TAG_W-1:0] t);
    return (t == LAST_TAG) ? FIRST_FREE : t + 1'b1;
  endfunction

  // Decide whether a write is absorbed into the map entry.
  function automatic fold_res_t fold_decide(
    input kind_e                   k,
    input width_e                  w,
    input logic signed [IMM_W-1:0] imm,
    input map_ent_t                src,
    input logic [TAG_W-1:0]        new_tag
  );
    fold_res_t               r;
    logic signed [SUM_W-1:0] ofs_x;
    logic signed [SUM_W-1:0] imm_x;
    logic signed [SUM_W-1:0] sum;
    logic [TAG_W-1:0]        base;
    logic                    cand;
    logic                    fits;
    ofs_x = SUM_W'(src.ofs);
    imm_x = SUM_W'(imm);
    base  = src.base;
    cand  = 1'b1;
    case (k)
      K_MOVI: begin sum = imm_x;          base = ZERO_TAG; end
      K_ADDI: sum = ofs_x + imm_x;
      K_SUBI: sum = ofs_x - imm_x;
      K_INC:  sum = ofs_x + SUM_W'(1);
      default: begin sum = '0; cand = 1'b0; end
    endcase
    fits   = (sum >= SUM_W'(OFS_MIN)) && (sum <= SUM_W'(OFS_MAX));
    r.fold = cand && (w == W64) && fits;
    if (r.fold) begin
      r.ent.base = base;
      r.ent.ofs  = sum[OFS_W-1:0];
      r.ent.fold = 1'b1;
    end else begin
      r.ent.base = new_tag;
      r.ent.ofs  = '0;
      r.ent.fold = 1'b0;
    end
    return r;
  endfunction
endpackage

// File: rtl/rnm_map_table.sv
module rnm_map_table
  import rnm_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    i_flush,
  input  logic [LANES-1:0]        i_wr_en,
  input  logic [AREG_W-1:0]       i_wr_idx [LANES],
  input  map_ent_t                i_wr_ent [LANES],
  output map_ent_t                o_rd     [ARCH_N]
);
  map_ent_t tbl_q [ARCH_N];
  map_ent_t tbl_d [ARCH_N];
  logic     upd_en;

  always_comb begin
    upd_en = i_flush | (|i_wr_en);
    tbl_d  = tbl_q;
    if (i_flush) begin
      for (int a = 0; a < ARCH_N; a++) tbl_d[a] = ident_ent(a);
    end else begin
      // later lanes overwrite earlier ones
      for (int l = 0; l < LANES; l++) begin
        if (i_wr_en[l]) tbl_d[i_wr_idx[l]] = i_wr_ent[l];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < ARCH_N; a++) tbl_q[a] <= ident_ent(a);
    end else if (upd_en) begin
      tbl_q <= tbl_d;
    end
  end

  assign o_rd = tbl_q;
endmodule

// File: rtl/rnm_alloc_ctr.sv
module rnm_alloc_ctr
  import rnm_pkg::*;
#(
  parameter int LANES = 2,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i_flush,
  input  logic [CNT_W-1:0] i_n_alloc,
  output logic [TAG_W-1:0] o_ptr
);
  logic [TAG_W-1:0] ptr_q;
  logic [TAG_W-1:0] ptr_d;
  logic             ptr_en;

  always_comb begin
    ptr_en = i_flush | (i_n_alloc != '0);
    ptr_d  = ptr_q;
    if (i_flush) begin
      ptr_d = FIRST_FREE;
    end else begin
      for (int n = 0; n < LANES; n++) begin
        if (CNT_W'(n) < i_n_alloc) ptr_d = tag_next(ptr_d);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= FIRST_FREE;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign o_ptr = ptr_q;
endmodule

// File: rtl/rnm_opnd_port.sv
module rnm_opnd_port
  import rnm_pkg::*;
(
  input  map_ent_t                i_ent,
  input  logic                    i_is_count,
  output logic [TAG_W-1:0]        o_tag,
  output logic signed [OFS_W-1:0] o_ofs,
  output logic                    o_ovld,
  output logic                    o_slow
);
  assign o_tag  = i_ent.base;
  assign o_ofs  = i_ent.ofs;
  assign o_ovld = i_ent.fold;
  assign o_slow = i_ent.fold & i_is_count;
endmodule

// File: rtl/rnm_imm_rename.sv
module rnm_imm_rename
  import rnm_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    i_flush,
  input  logic [LANES-1:0]        i_vld,
  input  logic [LANES*KIND_W-1:0] i_kind,
  input  logic [LANES*WID_W-1:0]  i_width,
  input  logic [LANES*AREG_W-1:0] i_dst,
  input  logic [LANES*AREG_W-1:0] i_srca,
  input  logic [LANES*AREG_W-1:0] i_srcb,
  input  logic [LANES*IMM_W-1:0]  i_imm,
  output logic [LANES*TAG_W-1:0]  o_a_tag,
  output logic [LANES*OFS_W-1:0]  o_a_ofs,
  output logic [LANES-1:0]        o_a_ovld,
  output logic [LANES*TAG_W-1:0]  o_b_tag,
  output logic [LANES*OFS_W-1:0]  o_b_ofs,
  output logic [LANES-1:0]        o_b_ovld,
  output logic [LANES-1:0]        o_b_slow,
  output logic [LANES-1:0]        o_folded,
  output logic [LANES-1:0]        o_issue,
  output logic [LANES*TAG_W-1:0]  o_dst_tag,
  output logic [LANES*2-1:0]      o_lat
);
  localparam int CNT_W = $clog2(LANES + 1);

  map_ent_t          rd_ent  [ARCH_N];
  map_ent_t          wr_ent  [LANES];
  logic [AREG_W-1:0] wr_idx  [LANES];
  logic [LANES-1:0]  wr_en;
  map_ent_t          ea      [LANES];
  map_ent_t          eb      [LANES];
  logic [LANES-1:0]  fold_l;
  logic [LANES-1:0]  alloc_l;
  logic [TAG_W-1:0]  dtag    [LANES];
  logic [CNT_W-1:0]  n_alloc;
  logic [TAG_W-1:0]  alloc_ptr;

  // In-order lane chain: each lane sees the writes of the lanes before it.
  always_comb begin
    logic [TAG_W-1:0] cur;
    fold_res_t        fr;
    cur     = alloc_ptr;
    n_alloc = '0;
    for (int l = 0; l < LANES; l++) begin
      ea[l] = rd_ent[i_srca[l*AREG_W +: AREG_W]];
      eb[l] = rd_ent[i_srcb[l*AREG_W +: AREG_W]];
      for (int j = 0; j < LANES; j++) begin
        if (j < l && i_vld[j]) begin
          if (i_dst[j*AREG_W +: AREG_W] == i_srca[l*AREG_W +: AREG_W]) ea[l] = wr_ent[j];
          if (i_dst[j*AREG_W +: AREG_W] == i_srcb[l*AREG_W +: AREG_W]) eb[l] = wr_ent[j];
        end
      end
      fr = fold_decide(kind_e'(i_kind[l*KIND_W +: KIND_W]),
                       width_e'(i_width[l*WID_W +: WID_W]),
                       i_imm[l*IMM_W +: IMM_W], ea[l], cur);
      wr_ent[l]  = fr.ent;
      wr_idx[l]  = i_dst[l*AREG_W +: AREG_W];
      wr_en[l]   = i_vld[l];
      fold_l[l]  = i_vld[l] & fr.fold;
      alloc_l[l] = i_vld[l] & ~fr.fold;
      dtag[l]    = alloc_l[l] ? cur : ZERO_TAG;
      if (alloc_l[l]) begin
        cur     = tag_next(cur);
        n_alloc = n_alloc + 1'b1;
      end
    end
  end

  rnm_map_table #(.LANES(LANES)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .i_flush  (i_flush),
    .i_wr_en  (wr_en),
    .i_wr_idx (wr_idx),
    .i_wr_ent (wr_ent),
    .o_rd     (rd_ent)
  );

  rnm_alloc_ctr #(.LANES(LANES)) u_alloc (
    .clk       (clk),
    .rst_n     (rst_n),
    .i_flush   (i_flush),
    .i_n_alloc (n_alloc),
    .o_ptr     (alloc_ptr)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic is_shift;
    logic a_slow_unused;
    logic b_slow;
    assign is_shift = (i_kind[g*KIND_W +: KIND_W] == K_SHIFT);

    rnm_opnd_port u_pa (
      .i_ent      (ea[g]),
      .i_is_count (1'b0),
      .o_tag      (o_a_tag[g*TAG_W +: TAG_W]),
      .o_ofs      (o_a_ofs[g*OFS_W +: OFS_W]),
      .o_ovld     (o_a_ovld[g]),
      .o_slow     (a_slow_unused)
    );

    rnm_opnd_port u_pb (
      .i_ent      (eb[g]),
      .i_is_count (is_shift),
      .o_tag      (o_b_tag[g*TAG_W +: TAG_W]),
      .o_ofs      (o_b_ofs[g*OFS_W +: OFS_W]),
      .o_ovld     (o_b_ovld[g]),
      .o_slow     (b_slow)
    );

    assign o_b_slow[g]             = b_slow;
    assign o_folded[g]             = fold_l[g];
    assign o_issue[g]              = alloc_l[g];
    assign o_dst_tag[g*TAG_W +: TAG_W] = dtag[g];
    assign o_lat[g*2 +: 2] = !i_vld[g] ? 2'd0 :
                             fold_l[g] ? 2'd0 :
                             (is_shift && b_slow) ? 2'd3 : 2'd1;
  end
endmodule

// File: rtl/rnm_imm_rename_chk.sv
module rnm_imm_rename_chk
  import rnm_pkg::*;
#(
  parameter int LANES = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    i_flush,
  input logic [LANES-1:0]        i_vld,
  input logic [LANES*KIND_W-1:0] i_kind,
  input logic [LANES*WID_W-1:0]  i_width,
  input logic [LANES*AREG_W-1:0] i_srca,
  input logic [LANES*IMM_W-1:0]  i_imm,
  input logic [LANES*TAG_W-1:0]  o_a_tag,
  input logic [LANES*OFS_W-1:0]  o_a_ofs,
  input logic [LANES-1:0]        o_a_ovld,
  input logic [LANES*OFS_W-1:0]  o_b_ofs,
  input logic [LANES-1:0]        o_b_ovld,
  input logic [LANES-1:0]        o_b_slow,
  input logic [LANES-1:0]        o_folded,
  input logic [LANES-1:0]        o_issue,
  input logic [LANES*TAG_W-1:0]  o_dst_tag,
  input logic [LANES*2-1:0]      o_lat
);
  for (genvar g = 0; g < LANES; g++) begin : g_chk
    logic is_shift;
    logic is_load;
    logic movi64_fit;
    assign is_shift   = (i_kind[g*KIND_W +: KIND_W] == K_SHIFT);
    assign is_load    = (i_kind[g*KIND_W +: KIND_W] == K_LOAD);
    assign movi64_fit = (i_kind[g*KIND_W +: KIND_W] == K_MOVI) &&
                        (i_width[g*WID_W +: WID_W] == W64) &&
                        ($signed(i_imm[g*IMM_W +: IMM_W]) >= OFS_MIN) &&
                        ($signed(i_imm[g*IMM_W +: IMM_W]) <= OFS_MAX);

    p_movi_fold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (i_vld[g] && movi64_fit) |-> o_folded[g]);

    p_fold_wide_r3: assert property (@(posedge clk) disable iff (!rst_n)
      o_folded[g] |-> (i_width[g*WID_W +: WID_W] == W64));

    p_load_plain_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (i_vld[g] && is_load) |-> (o_issue[g] && !o_folded[g]));

    p_plain_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((!o_a_ovld[g] -> o_a_ofs[g*OFS_W +: OFS_W] == '0) &&
       (!o_b_ovld[g] -> o_b_ofs[g*OFS_W +: OFS_W] == '0)));

    p_slow_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      o_b_slow[g] |-> (is_shift && o_b_ovld[g]));

    p_slow_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (i_vld[g] && is_shift && o_b_ovld[g]) |-> (o_lat[g*2 +: 2] == 2'd3));

    p_issue_tag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      o_issue[g] |-> (o_dst_tag[g*TAG_W +: TAG_W] >= FIRST_FREE));
  end

  p_flush_ident_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(i_flush) |-> ((o_a_tag[TAG_W-1:0] == TAG_W'(i_srca[AREG_W-1:0]) + 1'b1) &&
                        !o_a_ovld[0]));
endmodule

bind rnm_imm_rename rnm_imm_rename_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .i_flush   (i_flush),
  .i_vld     (i_vld),
  .i_kind    (i_kind),
  .i_width   (i_width),
  .i_srca    (i_srca),
  .i_imm     (i_imm),
  .o_a_tag   (o_a_tag),
  .o_a_ofs   (o_a_ofs),
  .o_a_ovld  (o_a_ovld),
  .o_b_ofs   (o_b_ofs),
  .o_b_ovld  (o_b_ovld),
  .o_b_slow  (o_b_slow),
  .o_folded  (o_folded),
  .o_issue   (o_issue),
  .o_dst_tag (o_dst_tag),
  .o_lat     (o_lat)
);

// File: tb/tb_rnm_imm_rename.sv
module tb_rnm_imm_rename;
  import rnm_pkg::*;
  localparam int L = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic i_flush = 1'b0;
  logic [L-1:0]        i_vld   = '0;
  logic [L*KIND_W-1:0] i_kind  = '0;
  logic [L*WID_W-1:0]  i_width = '0;
  logic [L*AREG_W-1:0] i_dst   = '0;
  logic [L*AREG_W-1:0] i_srca  = '0;
  logic [L*AREG_W-1:0] i_srcb  = '0;
  logic [L*IMM_W-1:0]  i_imm   = '0;
  logic [L*TAG_W-1:0]  o_a_tag, o_b_tag, o_dst_tag;
  logic [L*OFS_W-1:0]  o_a_ofs, o_b_ofs;
  logic [L-1:0]        o_a_ovld, o_b_ovld, o_b_slow, o_folded, o_issue;
  logic [L*2-1:0]      o_lat;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rnm_imm_rename #(.LANES(L)) dut (.*);

  typedef struct packed {
    logic [2:0] k; logic [1:0] w; logic [3:0] d; logic [3:0] a; logic [3:0] b;
    logic signed [31:0] imm; logic f; logic [5:0] dt;
    logic [5:0] at; logic signed [10:0] ao; logic av;
    logic [5:0] bt; logic signed [10:0] bo; logic bv; logic bs; logic [1:0] lat;
  } vec_t;

  // kind: 0 ALU 1 SHIFT 2 MOVI 3 ADDI 4 SUBI 5 INC 6 LOAD ; width: 0=8 1=32 2=64
  localparam vec_t VECS [18] = '{
    '{2,2, 1, 0,0,    5, 1, 0,  1,    0,0,  1,0,0,0, 0},  // R2 movi 5
    '{1,2, 2, 3,1,    0, 0,17,  4,    0,0,  0,5,1,1, 3},  // R7 R9 slow shift count
    '{0,2, 3, 1,1,    0, 0,18,  0,    5,1,  0,5,1,0, 1},  // R6 R7 andn no penalty
    '{2,2, 4, 0,0, 1023, 1, 0,  1,    0,0,  1,0,0,0, 0},  // R2 upper edge
    '{2,2, 5, 0,0, 1024, 0,19,  1,    0,0,  1,0,0,0, 1},  // R2 out of range
    '{2,2, 6, 0,0,-1024, 1, 0,  1,    0,0,  1,0,0,0, 0},  // R2 lower edge
    '{5,2, 4, 4,0,    0, 0,20,  0, 1023,1,  1,0,0,0, 1},  // R5 1023+1 abandons
    '{3,2, 7, 2,0,   10, 1, 0, 17,    0,0,  1,0,0,0, 0},  // R5 add onto plain
    '{4,2, 7, 7,0,    3, 1, 0, 17,   10,1,  1,0,0,0, 0},  // R5 accumulate
    '{1,2, 8, 7,8,    0, 0,21, 17,    7,1,  9,0,0,0, 1},  // R7 folded on A only
    '{2,1, 9, 0,0,    1, 0,22,  1,    0,0,  1,0,0,0, 1},  // R3 32-bit move
    '{2,0,10, 0,0,    1, 0,23,  1,    0,0,  1,0,0,0, 1},  // R3 8-bit move
    '{6,2, 1, 0,0,    0, 0,24,  1,    0,0,  1,0,0,0, 1},  // R4 load over fold
    '{1,2,11, 0,1,    0, 0,25,  1,    0,0, 24,0,0,0, 1},  // R4 count now plain
    '{5,1, 6, 6,0,    0, 0,26,  0,-1024,1,  1,0,0,0, 1},  // R3 32-bit inc
    '{3,2,12, 6,0,   -1, 1, 0, 26,    0,0,  1,0,0,0, 0},  // R5 negative add
    '{4,2,12,12,0, 1024, 0,27, 26,   -1,1,  1,0,0,0, 1},  // R5 below -1024
    '{3,2,13, 0,0, 2000, 0,28,  1,    0,0,  1,0,0,0, 1}   // R5 imm too large
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put(input int l, input bit v, input int k, input int w, input int d,
                     input int a, input int b, input int imm);
    i_vld[l] = v;
    i_kind[l*KIND_W +: KIND_W] = KIND_W'(k);
    i_width[l*WID_W +: WID_W]  = WID_W'(w);
    i_dst[l*AREG_W +: AREG_W]  = AREG_W'(d);
    i_srca[l*AREG_W +: AREG_W] = AREG_W'(a);
    i_srcb[l*AREG_W +: AREG_W] = AREG_W'(b);
    i_imm[l*IMM_W +: IMM_W]    = IMM_W'(imm);
  endtask

  function automatic int a_tag(int l);  return int'(o_a_tag[l*TAG_W +: TAG_W]); endfunction
  function automatic int b_tag(int l);  return int'(o_b_tag[l*TAG_W +: TAG_W]); endfunction
  function automatic int d_tag(int l);  return int'(o_dst_tag[l*TAG_W +: TAG_W]); endfunction
  function automatic int a_ofs(int l);  return int'($signed(o_a_ofs[l*OFS_W +: OFS_W])); endfunction
  function automatic int b_ofs(int l);  return int'($signed(o_b_ofs[l*OFS_W +: OFS_W])); endfunction
  function automatic int lat(int l);    return int'(o_lat[l*2 +: 2]); endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, nothing valid
    put(0, 0, 0, 2, 0, 5, 15, 0);
    put(1, 0, 0, 2, 0, 0, 0, 0);
    #2;
    chk("R1", "reset a tag", a_tag(0), 6);
    chk("R1", "reset b tag", b_tag(0), 16);
    chk("R1", "reset a ovld", int'(o_a_ovld[0]), 0);
    chk("R1", "reset a ofs", a_ofs(0), 0);
    chk("R1", "idle dst tag", d_tag(0), 0);

    // table walk in lane 0
    for (int n = 0; n < 18; n++) begin
      @(negedge clk);
      put(0, 1, VECS[n].k, VECS[n].w, VECS[n].d, VECS[n].a, VECS[n].b, VECS[n].imm);
      #2;
      chk("R2 R3 R4 R5", $sformatf("v%0d folded", n), int'(o_folded[0]), int'(VECS[n].f));
      chk("R9", $sformatf("v%0d dst tag", n), d_tag(0), int'(VECS[n].dt));
      chk("R6", $sformatf("v%0d a tag", n), a_tag(0), int'(VECS[n].at));
      chk("R6", $sformatf("v%0d a ofs", n), a_ofs(0), int'(VECS[n].ao));
      chk("R6", $sformatf("v%0d a ovld", n), int'(o_a_ovld[0]), int'(VECS[n].av));
      chk("R6", $sformatf("v%0d b tag", n), b_tag(0), int'(VECS[n].bt));
      chk("R6", $sformatf("v%0d b ofs", n), b_ofs(0), int'(VECS[n].bo));
      chk("R6", $sformatf("v%0d b ovld", n), int'(o_b_ovld[0]), int'(VECS[n].bv));
      chk("R7", $sformatf("v%0d b slow", n), int'(o_b_slow[0]), int'(VECS[n].bs));
      chk("R7", $sformatf("v%0d latency", n), lat(0), int'(VECS[n].lat));
    end

    // R10 flush
    @(negedge clk);
    put(0, 0, 0, 2, 0, 0, 0, 0);
    i_flush = 1'b1;
    @(negedge clk);
    i_flush = 1'b0;
    put(0, 1, 0, 2, 14, 1, 13, 0);
    #2;
    chk("R10", "flushed a tag", a_tag(0), 2);
    chk("R10", "flushed a ovld", int'(o_a_ovld[0]), 0);
    chk("R10", "flushed b tag", b_tag(0), 14);
    chk("R10", "alloc restart", d_tag(0), 17);

    // R8 lane 1 sees lane 0 fold; shift count slow
    @(negedge clk);
    put(0, 1, 2, 2, 3, 0, 0, 100);
    put(1, 1, 1, 2, 4, 5, 3, 0);
    #2;
    chk("R8", "l0 folded", int'(o_folded[0]), 1);
    chk("R8", "l1 b tag", b_tag(1), 0);
    chk("R8", "l1 b ofs", b_ofs(1), 100);
    chk("R7", "l1 slow", int'(o_b_slow[1]), 1);
    chk("R7", "l1 latency", lat(1), 3);
    chk("R9", "l1 tag skips fold", d_tag(1), 18);

    // R8 same destination; lane 1 reads lane 0's new tag
    @(negedge clk);
    put(0, 1, 0, 2, 5, 0, 0, 0);
    put(1, 1, 0, 2, 5, 5, 0, 0);
    #2;
    chk("R9", "l0 tag", d_tag(0), 19);
    chk("R9", "l1 tag", d_tag(1), 20);
    chk("R8", "l1 bypass tag", a_tag(1), 19);
    chk("R8", "l1 bypass ovld", int'(o_a_ovld[1]), 0);

    // R8 R5 two folds chained in one group
    @(negedge clk);
    put(0, 1, 2, 2, 2, 0, 0, 7);
    put(1, 1, 5, 2, 2, 2, 0, 0);
    #2;
    chk("R8", "l1 sees movi ofs", a_ofs(1), 7);
    chk("R8", "l1 sees movi base", a_tag(1), 0);
    chk("R5", "l1 inc folded", int'(o_folded[1]), 1);
    chk("R5", "l1 inc latency", lat(1), 0);

    @(negedge clk);
    put(0, 1, 0, 2, 14, 5, 2, 0);
    put(1, 0, 0, 2, 0, 0, 0, 0);
    #2;
    chk("R8", "later lane wins", a_tag(0), 20);
    chk("R5", "chained ofs", b_ofs(0), 8);
    chk("R5", "chained base", b_tag(0), 0);
    chk("R7", "ALU no slow", int'(o_b_slow[0]), 0);
    chk("R7", "ALU latency", lat(0), 1);
    chk("R9", "next tag", d_tag(0), 21);

    // R9 wrap from 63 to 17
    for (int t = 22; t <= 64; t++) begin
      @(negedge clk);
      put(0, 1, 0, 2, 15, 0, 0, 0);
      #2;
      chk("R9", "wrap sequence", d_tag(0), (t == 64) ? 17 : t);
    end

    @(negedge clk);
    put(0, 0, 0, 2, 0, 0, 0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule